// File: doc/BRIEF.md
# Strobe-Ordered Cycle Decoder with Compare Test Mode

This block sits on the device side of a multiplexed-address dynamic memory. It watches the row strobe, the two per-lane column strobes and the write enable, all sampled on a fast system clock. When the row strobe falls, it looks at the order in which the strobes arrived and classifies the memory cycle: a plain row cycle, a counter-driven refresh, or a refresh with write enable low that also enters a compare test mode. It keeps a 10-bit refresh row counter and reports the row that the current cycle touches.

A small register array stands in for the storage, so that reads, early writes, page-mode column accesses and hidden refresh can be exercised end to end. In test mode, column address bit 0 is ignored. A write stores its data into both words of the addressed pair. A read returns a single agree/disagree result on every data lane. Test mode is left only by a row-only refresh or a counter refresh. Ordinary accesses and repeated test-entry cycles leave it set.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After a synchronous active-low reset, cyc_code is 00 (idle), act_row is 0, test_mode is 0, dout_en is 0, and the refresh counter holds 0, so the first counter refresh reports row 0.
- R2: If both column strobes are high when the row strobe falls, cyc_code becomes 01 (row cycle) and act_row takes the addr value present at the fall.
- R3: If any column strobe is low and we_n is high when the row strobe falls, cyc_code becomes 10 (counter refresh), act_row takes the counter value, and the counter then advances by one.
- R4: If any column strobe is low and we_n is low when the row strobe falls, cyc_code becomes 11 (test entry), test_mode is set, and the counter row is used and advanced exactly as in R3.
- R5: cyc_code is held unchanged while the row strobe stays low and returns to 00 once the row strobe rises.
- R6: The refresh counter wraps from 1023 to 0.
- R7: A row cycle (code 01) with no column strobe fall before the row strobe rises gives a one-clock ras_only_done pulse at the rise, and that pulse clears test_mode.
- R8: A counter refresh (code 10) clears test_mode. Row-cycle reads and writes and further test-entry cycles leave it set.
- R9: In a row cycle, a column strobe fall with we_n high drives dout with the word at index {row[2:0], col[1:0]} and raises dout_en until both column strobes are high. With we_n low, din is written only into the lanes whose strobe is low (bit 0 follows cas_n[0], bit 1 follows cas_n[1]), and dout_en stays 0.
- R10: Several column strobe falls within one row-strobe-low period (page mode) each access their own column.
- R11: In test mode, col[0] is ignored. A write stores the enabled lanes of din into both words of the pair {row[2:0], col[1], 0/1}. A read outputs all ones if all four bits of the pair agree and all zeros otherwise.
- R12: Hidden refresh: after a read, if the column strobes stay low while the row strobe rises and falls again, the cycle is a counter refresh, and dout_en and dout keep the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 2 | Per-lane column strobes, active low; bit i gates data lane i |
| we_n | input | 1 | Write enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| din | input | 2 | Write data |
| cyc_code | output | 2 | Cycle type: 00 idle, 01 row, 10 counter refresh, 11 test entry |
| act_row | output | 10 | Row used by the current cycle |
| ras_only_done | output | 1 | One-clock pulse when a row cycle ends without a column access |
| test_mode | output | 1 | Compare test mode active |
| dout | output | 2 | Read data or compare result |
| dout_en | output | 1 | Read data valid on dout |

## Verification
A corrupted refresh counter shows up on act_row at the next counter refresh. The bench predicts every counter row from its own tally, so a skipped increment or a bad wrap is caught on the cycle where it first occurs. A wrong test-mode flag is caught within one access, because a test read returns a compare pattern rather than stored data. A misclassified strobe order changes cyc_code two clocks after the row strobe falls. A dropped output enable breaks the hidden-refresh data on the next refresh that follows a read.

// File: rtl/dcd_pkg.sv
// Package: shared cycle-type encoding for the strobe-ordered cycle decoder.
// Assumes: two-bit codes are visible at the top-level port cyc_code.
package dcd_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'b00,
        CYC_ROW   = 2'b01,
        CYC_CREF  = 2'b10,
        CYC_TENTR = 2'b11
    } cyc_t;
endpackage

// File: rtl/dcd_strobe_sampler.sv
// Module: registers the strobes, address and data once, keeps the previous
// strobe samples, and derives edge events from them.
// Assumes: inputs are already synchronous to clk; one flop stage is enough.
module dcd_strobe_sampler #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic [LANES-1:0]  cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  din,
    output logic              ras_s,
    output logic              ras_p,
    output logic [LANES-1:0]  cas_s,
    output logic              we_s,
    output logic [ADDR_W-1:0] addr_s,
    output logic [LANES-1:0]  din_s,
    output logic              cas_hi_s,
    output logic              cas_hi_p,
    output logic              ras_fall,
    output logic              ras_rise,
    output logic              cas_fall,
    output logic              cas_rel
);
    logic [LANES-1:0] cas_p;

    // Capture the current pins and keep the previous strobe samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_s  <= 1'b1;
            ras_p  <= 1'b1;
            cas_s  <= '1;
            cas_p  <= '1;
            we_s   <= 1'b1;
            addr_s <= '0;
            din_s  <= '0;
        end else begin
            ras_s  <= ras_n;
            ras_p  <= ras_s;
            cas_s  <= cas_n;
            cas_p  <= cas_s;
            we_s   <= we_n;
            addr_s <= addr;
            din_s  <= din;
        end
    end

    // Derive the edge events from the current and previous samples.
    always_comb begin
        cas_hi_s = &cas_s;
        cas_hi_p = &cas_p;
        ras_fall = ras_p & ~ras_s;
        ras_rise = ~ras_p & ras_s;
        cas_fall = cas_hi_p & ~cas_hi_s;
        cas_rel  = ~cas_hi_p & cas_hi_s;
    end
endmodule

// File: rtl/dcd_refresh_counter.sv
// Module: internal refresh row counter that advances on request and wraps
// from its top value back to zero.
// Assumes: adv is a single-clock request; one step per request.
module dcd_refresh_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    // Step the counter on each request and wrap at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv) begin
            if (cnt == CNT_TOP) cnt <= '0;
            else                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dcd_cycle_classifier.sv
// Module: classifies each cycle at the row strobe fall, latches the active
// row, runs the test-mode flag, and flags a row cycle that ended without a
// column access.
// Assumes: the sampler delivers one-clock edge events; the code is held
// until the row strobe rises.
module dcd_cycle_classifier
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_s,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              cas_hi_s,
    input  logic              we_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [ADDR_W-1:0] cnt,
    output cyc_t              cyc_code,
    output logic [ADDR_W-1:0] row_q,
    output logic              test_mode,
    output logic              ro_done,
    output logic              cnt_adv,
    output logic              acc_en
);
    logic cas_seen;
    logic ro_end;

    // Decode the counter request, column access and row-only end.
    always_comb begin
        cnt_adv = ras_fall & ~cas_hi_s;
        acc_en  = cas_fall & ~ras_s & (cyc_code == CYC_ROW);
        ro_end  = ras_rise & (cyc_code == CYC_ROW) & ~cas_seen;
    end

    // Update cycle code, active row, column-seen flag and row-only pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_code <= CYC_IDLE;
            row_q    <= '0;
            cas_seen <= 1'b0;
            ro_done  <= 1'b0;
        end else begin
            ro_done <= ro_end;
            if (ras_fall) begin
                cas_seen <= 1'b0;
                if (cas_hi_s) begin
                    cyc_code <= CYC_ROW;
                    row_q    <= addr_s;
                end else begin
                    cyc_code <= we_s ? CYC_CREF : CYC_TENTR;
                    row_q    <= cnt;
                end
            end else if (ras_rise) begin
                cyc_code <= CYC_IDLE;
            end else if (acc_en) begin
                cas_seen <= 1'b1;
            end
        end
    end

    // Enter test mode on a test-entry cycle; leave on refresh-only cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_mode <= 1'b0;
        end else if (ras_fall && !cas_hi_s) begin
            test_mode <= ~we_s;
        end else if (ro_end) begin
            test_mode <= 1'b0;
        end
    end
endmodule

// File: rtl/dcd_array_stub.sv
// Module: small register array standing in for storage. Handles normal
// reads and per-lane early writes, and the paired compare access of test
// mode, where column bit 0 is ignored.
// Assumes: acc_en is a one-clock access request inside a row cycle.
module dcd_array_stub #(
    parameter int ROW_IDX_W = 3,
    parameter int COL_IDX_W = 2,
    parameter int LANES     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic                 we_s,
    input  logic                 test_mode,
    input  logic [ROW_IDX_W-1:0] row_idx,
    input  logic [COL_IDX_W-1:0] col_idx,
    input  logic [LANES-1:0]     lane_en,
    input  logic [LANES-1:0]     din_s,
    input  logic                 cas_rel,
    output logic [LANES-1:0]     dout,
    output logic                 dout_en
);
    localparam int IDX_W = ROW_IDX_W + COL_IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [LANES-1:0] mem [DEPTH];
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_lo;
    logic [IDX_W-1:0] idx_hi;
    logic [LANES-1:0] wd_lo;
    logic [LANES-1:0] wd_hi;
    logic             agree;

    // Form the word index, the pair indices and the pair compare result.
    always_comb begin
        idx    = {row_idx, col_idx};
        idx_lo = {idx[IDX_W-1:1], 1'b0};
        idx_hi = {idx[IDX_W-1:1], 1'b1};
        wd_lo  = mem[idx_lo];
        wd_hi  = mem[idx_hi];
        agree  = (wd_lo == wd_hi) && (wd_lo == {LANES{wd_lo[0]}});
    end

    // Write enabled lanes, to one word or to both words of the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (acc_en && !we_s) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_en[l]) begin
                    if (test_mode) begin
                        mem[idx_lo][l] <= din_s[l];
                        mem[idx_hi][l] <= din_s[l];
                    end else begin
                        mem[idx][l] <= din_s[l];
                    end
                end
            end
        end
    end

    // Drive read data or the compare result until both strobes are high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else if (acc_en) begin
            dout_en <= we_s;
            if (we_s) dout <= test_mode ? {LANES{agree}} : mem[idx];
        end else if (cas_rel) begin
            dout_en <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_cycle_decoder.sv
// Module: top of the strobe-ordered cycle decoder. Samples the strobes,
// classifies cycles, runs the refresh counter and the test-mode flag, and
// reaches a small storage stub for reads and writes.
// Assumes: strobes are synchronous to clk and held several clocks per phase.
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int LANES     = 2,
    parameter int ROW_IDX_W = 3,
    parameter int COL_IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic [LANES-1:0]  cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  din,
    output logic [1:0]        cyc_code,
    output logic [ADDR_W-1:0] act_row,
    output logic              ras_only_done,
    output logic              test_mode,
    output logic [LANES-1:0]  dout,
    output logic              dout_en
);
    logic              ras_s, ras_p, we_s;
    logic [LANES-1:0]  cas_s, din_s;
    logic [ADDR_W-1:0] addr_s, cnt;
    logic              cas_hi_s, cas_hi_p;
    logic              ras_fall, ras_rise, cas_fall, cas_rel;
    logic              cnt_adv, acc_en;
    cyc_t              code_q;

    dcd_strobe_sampler #(.ADDR_W(ADDR_W), .LANES(LANES)) smp_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .ras_s(ras_s), .ras_p(ras_p), .cas_s(cas_s),
        .we_s(we_s), .addr_s(addr_s), .din_s(din_s), .cas_hi_s(cas_hi_s),
        .cas_hi_p(cas_hi_p), .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rel(cas_rel)
    );

    dcd_refresh_counter #(.CNT_W(ADDR_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .adv(cnt_adv), .cnt(cnt)
    );

    dcd_cycle_classifier #(.ADDR_W(ADDR_W)) cls_i (
        .clk(clk), .rst_n(rst_n), .ras_s(ras_s), .ras_fall(ras_fall),
        .ras_rise(ras_rise), .cas_fall(cas_fall), .cas_hi_s(cas_hi_s),
        .we_s(we_s), .addr_s(addr_s), .cnt(cnt), .cyc_code(code_q),
        .row_q(act_row), .test_mode(test_mode), .ro_done(ras_only_done),
        .cnt_adv(cnt_adv), .acc_en(acc_en)
    );

    dcd_array_stub #(
        .ROW_IDX_W(ROW_IDX_W), .COL_IDX_W(COL_IDX_W), .LANES(LANES)
    ) arr_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .we_s(we_s),
        .test_mode(test_mode), .row_idx(act_row[ROW_IDX_W-1:0]),
        .col_idx(addr_s[COL_IDX_W-1:0]), .lane_en(~cas_s), .din_s(din_s),
        .cas_rel(cas_rel), .dout(dout), .dout_en(dout_en)
    );

    // Present the cycle code as a plain vector at the port.
    always_comb cyc_code = code_q;
endmodule

// File: rtl/dcd_checker.sv
// Module: assertion checker bound to the cycle decoder top. Relates the
// sampled strobes to the code, the test-mode flag and the output enable.
// Assumes: it is attached through the bind statement at the end of this file.
module dcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ras_s,
    input logic       ras_p,
    input logic       cas_hi_s,
    input logic       cas_hi_p,
    input logic [1:0] cyc_code,
    input logic       test_mode,
    input logic       ras_only_done,
    input logic       dout_en
);
    AST_CODE_HELD_RAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_s && !ras_p) |=> $stable(cyc_code)); // R5
    AST_IDLE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_s && !ras_p) |=> (cyc_code == 2'b00)); // R5
    AST_TENTRY_SETS_TM: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_code == 2'b11) |-> test_mode); // R4
    AST_CREF_CLEARS_TM: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_code == 2'b10) |-> !test_mode); // R8
    AST_RO_CLEARS_TM: assert property (@(posedge clk) disable iff (!rst_n)
        ras_only_done |-> !test_mode); // R7
    AST_RO_FROM_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        ras_only_done |-> ($past(cyc_code) == 2'b01)); // R7
    AST_DOUT_OFF_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_hi_s && cas_hi_p) |-> !dout_en); // R9
endmodule

bind dram_cycle_decoder dcd_checker chk_i (
    .clk(clk), .rst_n(rst_n), .ras_s(ras_s), .ras_p(ras_p),
    .cas_hi_s(cas_hi_s), .cas_hi_p(cas_hi_p), .cyc_code(cyc_code),
    .test_mode(test_mode), .ras_only_done(ras_only_done), .dout_en(dout_en)
);

// File: tb/dram_cycle_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_cycle_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1;
    logic [1:0] cas_n = 2'b11;
    logic       we_n = 1'b1;
    logic [9:0] addr = '0;
    logic [1:0] din = '0;
    logic [1:0] cyc_code;
    logic [9:0] act_row;
    logic       ras_only_done;
    logic       test_mode;
    logic [1:0] dout;
    logic       dout_en;

    int checks = 0;
    int fails = 0;
    int ro_cnt = 0;
    int exp_cnt = 0;
    bit finished = 0;

    // vector: [24] write, [23:14] row, [13:4] col, [3:2] din, [1:0] expected
    localparam logic [24:0] VEC [8] = '{
        {1'b1, 10'd5,  10'd1, 2'b10, 2'b00},
        {1'b1, 10'd5,  10'd2, 2'b01, 2'b00},
        {1'b1, 10'd13, 10'd3, 2'b11, 2'b00},
        {1'b1, 10'd2,  10'd0, 2'b11, 2'b00},
        {1'b0, 10'd5,  10'd1, 2'b00, 2'b10},
        {1'b0, 10'd5,  10'd2, 2'b00, 2'b01},
        {1'b0, 10'd5,  10'd3, 2'b00, 2'b11},
        {1'b0, 10'd2,  10'd0, 2'b00, 2'b11}
    };

    dram_cycle_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .cyc_code(cyc_code), .act_row(act_row),
        .ras_only_done(ras_only_done), .test_mode(test_mode), .dout(dout),
        .dout_en(dout_en)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (ras_only_done) ro_cnt++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic open_row(input logic [9:0] row);
        addr = row; ras_n = 1'b0; step(4);
    endtask

    task automatic col_acc(input logic [9:0] col, input logic w, input logic [1:0] d,
                           input logic [1:0] lanes);
        addr = col; we_n = ~w; din = d; cas_n = lanes; step(4);
    endtask

    task automatic cas_up();
        cas_n = 2'b11; we_n = 1'b1; step(4);
    endtask

    task automatic ras_up();
        ras_n = 1'b1; step(4);
    endtask

    // Counter-driven refresh; we selects test entry when low.
    task automatic cbr(input logic we, output logic [9:0] row, output logic [1:0] code);
        we_n = we; cas_n = 2'b00; step(4);
        ras_n = 1'b0; step(4);
        row = act_row; code = cyc_code;
        ras_n = 1'b1; step(4);
        cas_n = 2'b11; we_n = 1'b1; step(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] r;
        logic [1:0] c;
        int bad;
        step(4);
        rst_n = 1'b1;
        step(2);
        check("R1 code", cyc_code, 2'b00);
        check("R1 row", act_row, 0);
        check("R1 test_mode", test_mode, 0);
        check("R1 dout_en", dout_en, 0);

        // vector table: single-access row cycles
        for (int i = 0; i < 8; i++) begin
            open_row(VEC[i][23:14]);
            check("R2 code", cyc_code, 2'b01);
            check("R2 row", act_row, VEC[i][23:14]);
            col_acc(VEC[i][13:4], VEC[i][24], VEC[i][3:2], 2'b00);
            if (VEC[i][24]) check("R9 write no dout_en", dout_en, 0);
            else begin
                check("R9 read dout_en", dout_en, 1);
                check("R9 read data", dout, VEC[i][1:0]);
            end
            check("R5 code held", cyc_code, 2'b01);
            cas_up();
            check("R9 dout_en off", dout_en, 0);
            ras_up();
            check("R5 idle after rise", cyc_code, 2'b00);
        end

        // counter refresh
        cbr(1'b1, r, c);
        check("R3 code", c, 2'b10);
        check("R3 row", r, exp_cnt); exp_cnt++;
        check("R5 idle", cyc_code, 2'b00);
        cbr(1'b1, r, c);
        check("R3 advance", r, exp_cnt); exp_cnt++;
        bad = 0;
        for (int i = 0; i < 1021; i++) begin
            cbr(1'b1, r, c);
            if (r != exp_cnt[9:0]) bad++;
            exp_cnt++;
        end
        check("R3 sequence", bad, 0);
        cbr(1'b1, r, c);
        check("R6 top", r, 1023); exp_cnt = 0;
        cbr(1'b1, r, c);
        check("R6 wrap", r, 0); exp_cnt = 1;

        // lane write: only lane 0 strobed
        open_row(10'd1);
        col_acc(10'd0, 1'b1, 2'b11, 2'b10);
        cas_up(); ras_up();
        open_row(10'd1);
        col_acc(10'd0, 1'b0, 2'b00, 2'b00);
        check("R9 lane write", dout, 2'b01);
        cas_up(); ras_up();

        // page mode
        open_row(10'd5);
        col_acc(10'd1, 1'b0, 2'b00, 2'b00);
        check("R10 page col1", dout, 2'b10);
        cas_up();
        col_acc(10'd2, 1'b0, 2'b00, 2'b00);
        check("R10 page col2", dout, 2'b01);
        cas_up(); ras_up();

        // row-only refresh outside test mode
        open_row(10'd7); ras_up();
        check("R7 pulse", ro_cnt, 1);

        // test entry
        cbr(1'b0, r, c);
        check("R4 code", c, 2'b11);
        check("R4 row", r, exp_cnt); exp_cnt++;
        check("R4 test_mode", test_mode, 1);
        open_row(10'd3);
        col_acc(10'd2, 1'b1, 2'b11, 2'b00);
        cas_up();
        col_acc(10'd3, 1'b0, 2'b00, 2'b00);
        check("R11 agree", dout, 2'b11);
        cas_up(); ras_up();
        open_row(10'd3);
        col_acc(10'd3, 1'b1, 2'b00, 2'b10);
        cas_up();
        col_acc(10'd2, 1'b0, 2'b00, 2'b00);
        check("R11 disagree", dout, 2'b00);
        cas_up(); ras_up();
        check("R8 kept by access", test_mode, 1);
        cbr(1'b0, r, c);
        check("R8 kept by entry", test_mode, 1);
        check("R4 row again", r, exp_cnt); exp_cnt++;
        cbr(1'b1, r, c);
        check("R8 cref clears", test_mode, 0); exp_cnt++;
        open_row(10'd3);
        col_acc(10'd2, 1'b0, 2'b00, 2'b00);
        check("R11 pair word lo", dout, 2'b10);
        cas_up();
        col_acc(10'd3, 1'b0, 2'b00, 2'b00);
        check("R11 pair word hi", dout, 2'b10);
        cas_up(); ras_up();

        // row-only refresh leaves test mode
        cbr(1'b0, r, c); exp_cnt++;
        check("R4 re-entry", test_mode, 1);
        open_row(10'd9); ras_up();
        check("R7 clears test", test_mode, 0);
        check("R7 pulse count", ro_cnt, 2);

        // hidden refresh
        open_row(10'd5);
        col_acc(10'd1, 1'b0, 2'b00, 2'b00);
        ras_n = 1'b1; step(4);
        ras_n = 1'b0; step(4);
        check("R12 code", cyc_code, 2'b10);
        check("R12 row", act_row, exp_cnt); exp_cnt++;
        check("R12 dout_en", dout_en, 1);
        check("R12 data", dout, 2'b10);
        cas_up();
        check("R12 release", dout_en, 0);
        ras_up();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule